// File: doc/BRIEF.md
# UART Receive FIFO with Inactivity Timeout

This block sits between a serial receiver and the host side of a UART. Received bytes are written into a small first-in first-out store. The host takes them out from the other end. A byte that arrives while the store is full is thrown away, and the block reports it with a one-cycle overrun pulse.

The block also holds the baud-rate divider. The divider turns the system clock into one tick per serial bit period. Each byte that is accepted restarts a timer of four character times, counted in those ticks. The length of a character follows from the configured frame format. When the line then stays quiet for the whole period, the block gives a single timeout pulse. The host can use that pulse to collect a partial batch of bytes that has not reached any fill threshold. A flush input empties the store and stops the timer.

Top module: `uart_rx_fifo_tmo`

## Requirements
- R1: After reset, `level` is 0, `empty` is 1, `full` is 0, and neither `overrun` nor `timeout` is asserted.
- R2: Bytes are read in the order they were accepted. `rd_data` always shows the oldest stored byte, and a read with `rd_en` removes it.
- R3: The store holds 16 bytes. `level` gives the number of stored bytes, `full` is 1 exactly when `level` is 16, and `empty` is 1 exactly when `level` is 0.
- R4: A write while the store is full and no read happens in the same cycle is dropped. `level` stays at 16, and `overrun` is high for exactly one cycle in the cycle after the write.
- R5: A write and a read in the same cycle, when the store is not empty, leave `level` unchanged and store the new byte. This also holds when the store is full, and no overrun is raised in that case.
- R6: A read while the store is empty has no effect: `level` stays 0.
- R7: A character lasts 1 start bit, plus the data bits, plus the parity bits, plus the stop bits. For the data length, `cfg_len` code 3 gives 6 bits, code 2 gives 7 bits and any other code gives 8 bits. For parity, `cfg_parity` codes 0 (even) and 1 (odd) add one bit; every other code adds none. For stop bits, `cfg_stop` code 3 gives 1 stop bit and any other code gives 2. The timeout period is 4 characters.
- R8: One bit period lasts (`cfg_pre8` ? 8 : 1) × `cfg_gen` × (`cfg_div` + 1) clock cycles. The timeout fires after the last accepted byte: more than (4·C − 1) bit periods and no more than 4·C bit periods later, where C is the character length in bits. With a one-cycle bit period, the delay is exactly 4·C cycles.
- R9: Every accepted byte restarts the timer. After expiry, `timeout` pulses for one cycle, and no further pulse follows until another byte is accepted.
- R10: `flush` empties the store (`level` 0, `empty` 1) and stops the timer, so no timeout follows a flush.
- R11: A byte dropped on overrun does not restart the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties the store and stops the timer |
| wr_en | input | 1 | Write strobe from the serial receiver |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Oldest stored byte |
| cfg_pre8 | input | 1 | Adds a divide-by-8 prescale to the bit clock |
| cfg_gen | input | 16 | Baud generator value |
| cfg_div | input | 8 | Baud divisor (divides by value + 1) |
| cfg_len | input | 2 | Data length code |
| cfg_parity | input | 3 | Parity code |
| cfg_stop | input | 2 | Stop bit code |
| level | output | 5 | Number of stored bytes |
| empty | output | 1 | Store empty |
| full | output | 1 | Store full |
| overrun | output | 1 | One-cycle pulse on a dropped byte |
| timeout | output | 1 | One-cycle pulse when the inactivity timer expires |

## Verification
The hardest situation to reach from the ports is a byte that is dropped on overrun while the timer is already part way through its count. In that case the timeout must still fall a fixed distance after the last accepted byte, and not after the dropped one. The stimulus fills the store at a one-cycle bit period, waits part of the timeout period, and then writes one more byte. This places the dropped byte well inside the running count, and the bench measures the expiry against the sixteenth write. Because the divider runs freely, the first tick after a write has no fixed phase at longer bit periods. The timeout at those settings is therefore checked against a window one bit period wide.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
   localparam int FRAME_W = 4;
   localparam int LOAD_W  = FRAME_W + 2;

   // bits in one serial character
   function automatic logic [FRAME_W-1:0] frame_bits(input logic [1:0] len_code,
                                                     input logic [2:0] par_code,
                                                     input logic [1:0] stop_code);
      int nb;
      nb = 1;
      case (len_code)
         2'd3:    nb = nb + 6;
         2'd2:    nb = nb + 7;
         default: nb = nb + 8;
      endcase
      if (par_code == 3'd0 || par_code == 3'd1) nb = nb + 1;
      nb = nb + ((stop_code == 2'd3) ? 1 : 2);
      return FRAME_W'(nb);
   endfunction
endpackage

// File: rtl/uart_rxq_baud.sv
module uart_rxq_baud #(
   parameter int PRESC_DIV = 8,
   parameter int GEN_W     = 16,
   parameter int DIV_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pre_sel,
   input  logic [GEN_W-1:0] gen,
   input  logic [DIV_W-1:0] div,
   output logic             bit_tick
);
   localparam int LIM_W = GEN_W + DIV_W;
   localparam int PC_W  = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

   logic             pre_en;
   logic [LIM_W-1:0] limit;
   logic [LIM_W-1:0] cnt;

   generate
      if (PRESC_DIV > 1) begin : g_pre
         logic [PC_W-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              pcnt <= '0;
            else if (!pre_sel)                       pcnt <= '0;
            else if (pcnt == PC_W'(PRESC_DIV - 1))   pcnt <= '0;
            else                                     pcnt <= pcnt + PC_W'(1);
         end
         assign pre_en = !pre_sel || (pcnt == PC_W'(PRESC_DIV - 1));
      end else begin : g_nopre
         assign pre_en = 1'b1;
      end
   endgenerate

   assign limit = LIM_W'(gen) * (LIM_W'(div) + LIM_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         bit_tick <= 1'b0;
      end else begin
         bit_tick <= 1'b0;
         if (pre_en && limit != '0) begin
            if (cnt >= limit - LIM_W'(1)) begin
               cnt      <= '0;
               bit_tick <= 1'b1;
            end else begin
               cnt <= cnt + LIM_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic                        push_req,
   input  logic [DATA_W-1:0]           wdata,
   input  logic                        pop_req,
   output logic [DATA_W-1:0]           rdata,
   output logic [$clog2(DEPTH):0]      count,
   output logic                        full,
   output logic                        empty,
   output logic                        push_ok,
   output logic                        ovr_pulse
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr;
   logic              pop_ok;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign pop_ok  = pop_req && !empty && !flush;
   assign push_ok = push_req && !flush && (!full || pop_ok);
   assign rdata   = mem[rptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr      <= '0;
         rptr      <= '0;
         count     <= '0;
         ovr_pulse <= 1'b0;
      end else if (flush) begin
         wptr      <= '0;
         rptr      <= '0;
         count     <= '0;
         ovr_pulse <= 1'b0;
      end else begin
         ovr_pulse <= push_req && full && !pop_ok;
         if (push_ok) wptr <= wptr + PTR_W'(1);
         if (pop_ok)  rptr <= rptr + PTR_W'(1);
         case ({push_ok, pop_ok})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/uart_rxq_timer.sv
module uart_rxq_timer #(
   parameter int LOAD_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop,
   input  logic              restart,
   input  logic [LOAD_W-1:0] load,
   input  logic              tick,
   output logic              expire
);
   logic [LOAD_W-1:0] rem;
   logic              armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem    <= '0;
         armed  <= 1'b0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (stop) begin
            rem   <= '0;
            armed <= 1'b0;
         end else if (restart) begin
            rem   <= load;
            armed <= 1'b1;
         end else if (armed && tick) begin
            if (rem == LOAD_W'(1)) begin
               rem    <= '0;
               armed  <= 1'b0;
               expire <= 1'b1;
            end else begin
               rem <= rem - LOAD_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/uart_rx_fifo_tmo.sv
module uart_rx_fifo_tmo #(
   parameter int DEPTH     = 16,
   parameter int DATA_W    = 8,
   parameter int GEN_W     = 16,
   parameter int DIV_W     = 8,
   parameter int PRESC_DIV = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     wr_en,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     rd_en,
   output logic [DATA_W-1:0]        rd_data,
   input  logic                     cfg_pre8,
   input  logic [GEN_W-1:0]         cfg_gen,
   input  logic [DIV_W-1:0]         cfg_div,
   input  logic [1:0]               cfg_len,
   input  logic [2:0]               cfg_parity,
   input  logic [1:0]               cfg_stop,
   output logic [$clog2(DEPTH):0]   level,
   output logic                     empty,
   output logic                     full,
   output logic                     overrun,
   output logic                     timeout
);
   import uart_rxq_pkg::*;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 5) begin : g_bad_width
         $error("DATA_W must be at least 5");
      end
   endgenerate

   logic              tick;
   logic              accepted;
   logic [LOAD_W-1:0] tmo_load;

   assign tmo_load = {frame_bits(cfg_len, cfg_parity, cfg_stop), 2'b00};

   uart_rxq_baud #(.PRESC_DIV(PRESC_DIV), .GEN_W(GEN_W), .DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .pre_sel(cfg_pre8), .gen(cfg_gen), .div(cfg_div),
      .bit_tick(tick));

   uart_rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push_req(wr_en), .wdata(wr_data),
      .pop_req(rd_en), .rdata(rd_data), .count(level), .full(full), .empty(empty),
      .push_ok(accepted), .ovr_pulse(overrun));

   uart_rxq_timer #(.LOAD_W(LOAD_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .stop(flush), .restart(accepted), .load(tmo_load),
      .tick(tick), .expire(timeout));
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
   parameter int DEPTH = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   flush,
   input logic                   wr_en,
   input logic                   rd_en,
   input logic [$clog2(DEPTH):0] level,
   input logic                   empty,
   input logic                   full,
   input logic                   overrun,
   input logic                   timeout
);
   localparam int CNT_W = $clog2(DEPTH) + 1;

   assert_flags_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNT_W'(DEPTH));

   assert_ovr_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(full && wr_en && !rd_en && !flush));

   assert_ovr_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> (level == $past(level)));

   assert_pushpop_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && !empty && !flush) |=> (level == $past(level)));

   assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && empty && !flush) |=> empty);

   assert_tmo_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout);

   assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && level == '0));

   assert_flush_no_tmo_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !timeout);
endmodule

bind uart_rx_fifo_tmo uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .rd_en(rd_en),
   .level(level), .empty(empty), .full(full), .overrun(overrun), .timeout(timeout));

// File: tb/sim_uart_rx_fifo_tmo.sv
module sim_uart_rx_fifo_tmo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_data;
   logic        cfg_pre8 = 1'b0;
   logic [15:0] cfg_gen = 16'd1;
   logic [7:0]  cfg_div = 8'd0;
   logic [1:0]  cfg_len = 2'd0;
   logic [2:0]  cfg_parity = 3'd4;
   logic [1:0]  cfg_stop = 2'd3;
   logic [4:0]  level;
   logic        empty, full, overrun, timeout;

   int errs = 0, checks = 0;
   int cyc = 0;
   int mcount = 0;
   int acc_cyc = 0;
   int tmo_cnt = 0, last_tmo = 0, ovr_cnt = 0;
   logic [7:0] sb[$];
   bit done = 0;

   uart_rx_fifo_tmo u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .cfg_pre8(cfg_pre8), .cfg_gen(cfg_gen),
      .cfg_div(cfg_div), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
      .cfg_stop(cfg_stop), .level(level), .empty(empty), .full(full),
      .overrun(overrun), .timeout(timeout));

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errs, checks);
   endtask

   // monitor: compares popped bytes with the scoreboard, counts pulses
   always @(negedge clk) begin
      if (rst_n) begin
         if (timeout) begin tmo_cnt++; last_tmo = cyc; end
         if (overrun) ovr_cnt++;
         if (rd_en && !empty && !flush) begin
            if (sb.size() == 0) chk(0, "R2 unexpected data", int'(rd_data), -1);
            else begin
               logic [7:0] e;
               e = sb.pop_front();
               chk(rd_data == e, "R2 order", int'(rd_data), int'(e));
            end
         end
      end
   end

   // driver: one cycle of write/read; called at posedge+1
   task automatic op(input bit w, input logic [7:0] d, input bit r);
      bit will_pop, acc;
      will_pop = r && mcount > 0;
      acc = w && (mcount < 16 || will_pop);
      wr_en = w; wr_data = d; rd_en = r;
      if (acc) sb.push_back(d);
      mcount = mcount + (acc ? 1 : 0) - (will_pop ? 1 : 0);
      @(posedge clk); #1;
      if (acc) acc_cyc = cyc;
      wr_en = 0; rd_en = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   task automatic do_flush();
      flush = 1; @(posedge clk); #1; flush = 0;
      sb.delete(); mcount = 0;
   endtask

   task automatic wait_tmo(input int maxc, output int delta);
      int t0;
      t0 = tmo_cnt;
      for (int i = 0; i < maxc && tmo_cnt == t0; i++) begin @(posedge clk); #1; end
      delta = (tmo_cnt > t0) ? (last_tmo - acc_cyc) : -1;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      int d, t0, o0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(level == 0, "R1 level", level, 0);
      chk(empty == 1 && full == 0, "R1 flags", {empty, full}, 2);
      chk(!overrun && !timeout, "R1 pulses", {overrun, timeout}, 0);
      rst_n = 1;
      idle(2);

      // R2 order
      op(1, 8'h11, 0); op(1, 8'h22, 0); op(1, 8'h33, 0);
      chk(level == 3, "R3 level after 3", level, 3);
      op(0, 0, 1); op(0, 0, 1); op(0, 0, 1);
      chk(empty == 1, "R2 drained", empty, 1);
      do_flush();

      // R3 fill; R4 overrun; R11 dropped byte does not rearm
      for (int i = 0; i < 16; i++) op(1, 8'(8'h40 + i), 0);
      chk(level == 16 && full == 1, "R3 full", level, 16);
      t0 = acc_cyc;
      idle(20);
      o0 = ovr_cnt;
      op(1, 8'hEE, 0);
      chk(overrun == 1, "R4 overrun pulse", overrun, 1);
      chk(level == 16, "R4 level kept", level, 16);
      idle(1);
      chk(overrun == 0 && ovr_cnt == o0 + 1, "R4 single pulse", ovr_cnt - o0, 1);
      acc_cyc = t0;
      wait_tmo(200, d);
      chk(d == 40, "R11 timeout from last accepted byte", d, 40);

      for (int i = 0; i < 16; i++) op(0, 0, 1);
      chk(level == 0 && empty == 1, "R2 all read", level, 0);
      // R6 read on empty
      op(0, 0, 1);
      chk(level == 0 && empty == 1, "R6 empty read ignored", level, 0);

      // R5 simultaneous push and pop
      op(1, 8'hA1, 0);
      op(1, 8'hB2, 1);
      chk(level == 1, "R5 level unchanged", level, 1);
      op(0, 0, 1);
      chk(level == 0, "R5 new byte stored", level, 0);
      do_flush();
      for (int i = 0; i < 16; i++) op(1, 8'(i), 0);
      o0 = ovr_cnt;
      op(1, 8'h55, 1);
      idle(1);
      chk(level == 16 && ovr_cnt == o0, "R5 full push+pop", level, 16);
      for (int i = 0; i < 16; i++) op(0, 0, 1);
      chk(empty == 1, "R5 byte order with push+pop", empty, 1);
      do_flush();

      // R9 rearm
      t0 = tmo_cnt;
      op(1, 8'h01, 0); idle(30); op(1, 8'h02, 0);
      wait_tmo(200, d);
      chk(d == 40, "R9 rearm delay", d, 40);
      chk(tmo_cnt == t0 + 1, "R9 one pulse", tmo_cnt - t0, 1);
      idle(100);
      chk(tmo_cnt == t0 + 1, "R9 no second pulse", tmo_cnt - t0, 1);
      do_flush();

      // R7 six data bits, even parity, one stop: 9 bits -> 36
      cfg_len = 2'd3; cfg_parity = 3'd0; cfg_stop = 2'd3;
      idle(2);
      op(1, 8'h07, 0);
      wait_tmo(400, d);
      chk(d == 36, "R7 6E1 timeout", d, 36);
      do_flush();

      // R7/R8 seven bits, odd, two stops: 11 bits; period 3*2=6 -> (43*6, 264]
      cfg_len = 2'd2; cfg_parity = 3'd1; cfg_stop = 2'd0;
      cfg_gen = 16'd3; cfg_div = 8'd1;
      idle(2);
      op(1, 8'h08, 0);
      wait_tmo(1000, d);
      chk(d > 258 && d <= 264, "R8 divided timeout window", d, 264);
      do_flush();

      // R8 prescale by 8, 8 bits, no parity (code 2), two stops: 11 bits -> (43*8, 352]
      cfg_pre8 = 1; cfg_gen = 16'd1; cfg_div = 8'd0;
      cfg_len = 2'd0; cfg_parity = 3'd2; cfg_stop = 2'd2;
      idle(2);
      op(1, 8'h09, 0);
      wait_tmo(1000, d);
      chk(d > 344 && d <= 352, "R8 prescaled timeout window", d, 352);
      do_flush();

      // R10 flush clears and stops timer
      cfg_pre8 = 0; cfg_len = 2'd0; cfg_parity = 3'd4; cfg_stop = 2'd3;
      idle(2);
      op(1, 8'hC3, 0); op(1, 8'hC4, 0);
      t0 = tmo_cnt;
      do_flush();
      chk(level == 0 && empty == 1, "R10 flush empties", level, 0);
      idle(100);
      chk(tmo_cnt == t0, "R10 no timeout after flush", tmo_cnt - t0, 0);

      done = 1;
      summary();
      $finish;
   end
endmodule